// File: doc/BRIEF.md
# Receive Packet Queue with Head Status

This block sits between a network receive path and a host. Bytes come in from the receive side, each tagged with an end-of-packet strobe, and an error code comes with the last byte. Whole packets are stored in a byte-wide circular data memory. A small descriptor queue beside it holds each stored packet's length and error code, so the host always sees a 16-bit status word for the oldest packet. The host pulls that packet out through a 16-bit word port and then drops it with a discard command. The discard works whether or not every byte has been read.

Admission is all or nothing. A packet that arrives while the descriptor queue is full is refused, and so is a packet that runs out of data memory part-way through. A refused packet leaves nothing behind and raises a diagnostic flag. A read with no bytes left in the head packet is a host error: it latches a sticky underrun flag and an adapter-failure output. Only the receive reset or the global reset clears them. The receive reset empties the whole block in a single cycle.

Top module: `rxq_pktbuf`

## Requirements
- R1: After reset, head_status reads 16'h8000, host_word reads 0, and flag_receiving, flag_stat_ovr, flag_rx_ovr, flag_rx_undr and adapter_fail are all low.
- R2: With at least one stored packet, head_status is {1'b0, code[3:0], len[10:0]}. Bit 15 is 0, bits 14..11 carry the packet's error code, and bits 10..0 carry its byte count, so bit 14 is set exactly for the error codes that start with 1.
- R3: The error code stored is the one on mac_code with the last byte, kept when it is one of 1000 (overrun), 1011 (runt), 1100 (alignment), 1101 (CRC), 1001 (oversize) or 0010 (dribble). Any other value is stored as 0000.
- R4: host_word shows the next unread bytes of the head packet: the earlier byte in bits 7..0 and the later byte in bits 15..8. When only one byte remains, bits 15..8 read 0. A host_rd pulse consumes two bytes, or one if only one remains.
- R5: Packets are presented in arrival order. After a discard, the next stored packet becomes the head in the following cycle.
- R6: At most MAX_PKTS (8) packets are stored. A packet whose first byte arrives while eight are stored is dropped whole and sets flag_stat_ovr. The flag clears in the cycle after a discard removes a packet.
- R7: A packet that would overflow the DEPTH-byte data memory is dropped whole, with none of its bytes kept, and sets flag_rx_ovr. Later packets that fit are stored normally. flag_rx_ovr clears after the next successful host_rd or discard.
- R8: A host_rd with the queue empty, or with no bytes left in the head packet, sets flag_rx_undr and adapter_fail. Both stay high through reads and discards until rx_reset or rst_n.
- R9: host_discard drops the head packet however much of it has been read, and the next packet's data starts at its own first byte. A discard with the queue empty changes nothing. A discard takes priority over a host_rd in the same cycle.
- R10: flag_receiving is high from the cycle after the first accepted byte of a packet until the cycle after its last byte. While the queue is empty, head_status reads {1'b1, 4'b0000, bytes received so far}.
- R11: A one-cycle rx_reset empties the data memory and the descriptor queue, clears every flag, abandons any packet in progress, and leaves head_status at 16'h8000 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Global reset, active low, asynchronous |
| rx_reset | input | 1 | Receive reset command, synchronous, one cycle |
| mac_valid | input | 1 | A receive byte is present this cycle |
| mac_byte | input | 8 | Receive byte |
| mac_eop | input | 1 | This byte is the last of its packet |
| mac_code | input | 4 | Error code, sampled with the last byte |
| host_rd | input | 1 | Consume the word shown on host_word |
| host_discard | input | 1 | Drop the head packet |
| head_status | output | 16 | Status word of the head packet, or incomplete indication |
| host_word | output | 16 | Next two unread bytes of the head packet |
| flag_receiving | output | 1 | A packet is being written |
| flag_stat_ovr | output | 1 | A packet was refused because the descriptor queue was full |
| flag_rx_ovr | output | 1 | A packet was refused because the data memory was full |
| flag_rx_undr | output | 1 | Sticky: the host read past the end of a packet |
| adapter_fail | output | 1 | Sticky failure indication, follows the underrun flag |

## Verification
The bench fills the descriptor queue to eight packets and sends a ninth. A design that counts one slot wrong would keep the ninth packet or lose the eighth, and the discards that follow would show it. It overflows the data memory in the middle of the third packet of 700 bytes, then checks that the next short packet's first word is its own data. A design that failed to rewind the write pointer would present stale bytes from the dropped packet there. It discards a half-read packet and checks the alignment of the next packet. It also reads past an odd-length end, where a design that cleared the sticky underrun on discard, or kept the stale high byte, would fail at once.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

   localparam int LEN_W  = 11;
   localparam int CODE_W = 4;

   typedef struct packed {
      logic [CODE_W-1:0] code;
      logic [LEN_W-1:0]  len;
   } pkt_desc_t;

   typedef enum logic [1:0] {
      WR_IDLE = 2'd0,
      WR_TAKE = 2'd1,
      WR_SKIP = 2'd2
   } wr_state_e;

   // keep the recognised error codes, fold everything else to "no error"
   function automatic logic [CODE_W-1:0] known_code(input logic [CODE_W-1:0] c);
      case (c)
         4'b1000, 4'b1001, 4'b1011,
         4'b1100, 4'b1101, 4'b0010: return c;
         default:                   return '0;
      endcase
   endfunction

endpackage

// File: rtl/rxq_bytemem.sv
module rxq_bytemem #(
   parameter int DEPTH = 2048,
   parameter int AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [7:0]    wdata,
   input  logic [AW-1:0] raddr_lo,
   input  logic [AW-1:0] raddr_hi,
   output logic [7:0]    rdata_lo,
   output logic [7:0]    rdata_hi
);

   logic [7:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (we) store[waddr] <= wdata;
   end

   assign rdata_lo = store[raddr_lo];
   assign rdata_hi = store[raddr_hi];

endmodule

// File: rtl/rxq_statq.sv
module rxq_statq
   import rxq_pkg::*;
#(
   parameter int SLOTS = 8,
   parameter int PW    = (SLOTS > 1) ? $clog2(SLOTS) : 1,
   parameter int CW    = $clog2(SLOTS + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          push,
   input  pkt_desc_t     push_desc,
   input  logic          pop,
   output pkt_desc_t     head,
   output logic [CW-1:0] count
);

   localparam logic [PW-1:0] LAST = PW'(SLOTS - 1);

   pkt_desc_t     slot [SLOTS];
   logic [PW-1:0] wr_ptr, rd_ptr;

   always_ff @(posedge clk) begin
      if (push) slot[wr_ptr] <= push_desc;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (clr) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
         if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
         case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: ;
         endcase
      end
   end

   assign head = slot[rd_ptr];

   // R6: the writer must never push into a full descriptor queue
   assert_no_push_full_R6: assert property (@(posedge clk) disable iff (!rst_n || clr)
      push |-> (count < CW'(SLOTS)));

   // R9: discard logic must never pop an empty queue
   assert_no_pop_empty_R9: assert property (@(posedge clk) disable iff (!rst_n || clr)
      pop |-> (count != '0));

endmodule

// File: rtl/rxq_pktbuf.sv
module rxq_pktbuf
   import rxq_pkg::*;
#(
   parameter int DEPTH       = 2048,
   parameter int MAX_PKTS    = 8,
   parameter bit SCRUB_CODES = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        rx_reset,
   input  logic        mac_valid,
   input  logic [7:0]  mac_byte,
   input  logic        mac_eop,
   input  logic [3:0]  mac_code,
   input  logic        host_rd,
   input  logic        host_discard,
   output logic [15:0] head_status,
   output logic [15:0] host_word,
   output logic        flag_receiving,
   output logic        flag_stat_ovr,
   output logic        flag_rx_ovr,
   output logic        flag_rx_undr,
   output logic        adapter_fail
);

   localparam int AW      = $clog2(DEPTH);
   localparam int PW      = AW + 1;
   localparam int CW      = $clog2(MAX_PKTS + 1);
   localparam int LEN_MAX = (1 << LEN_W) - 1;
   localparam logic [PW-1:0]    DEPTH_P = PW'(DEPTH);
   localparam logic [LEN_W-1:0] LEN_TOP = LEN_W'(LEN_MAX);

   if ((1 << AW) != DEPTH) begin : g_bad_depth
      $error("rxq_pktbuf: DEPTH must be a power of two");
   end
   if (DEPTH < 4 || DEPTH > (1 << LEN_W)) begin : g_bad_range
      $error("rxq_pktbuf: DEPTH out of range");
   end
   if (MAX_PKTS < 2) begin : g_bad_slots
      $error("rxq_pktbuf: MAX_PKTS must be at least 2");
   end

   wr_state_e        st_q, st_d;
   logic [PW-1:0]    wptr_c, wptr_t, rptr, used;
   logic [LEN_W-1:0] pkt_len, rd_off, remain, step;
   logic             stat_ovr_q, rx_ovr_q, rx_undr_q;
   logic             take_byte, refuse_slot, refuse_mem, commit;
   logic             q_full, q_empty, mem_full, len_full;
   logic             rd_ok, rd_bad, q_pop;
   logic [3:0]       code_in;
   logic [CW-1:0]    q_cnt;
   pkt_desc_t        q_head, push_desc;
   logic [AW-1:0]    ra_hi;
   logic [7:0]       rd_lo, rd_hi;

   if (SCRUB_CODES) begin : g_scrub
      assign code_in = known_code(mac_code);
   end else begin : g_raw
      assign code_in = mac_code;
   end

   assign used     = wptr_t - rptr;
   assign mem_full = (used == DEPTH_P);
   assign len_full = (pkt_len == LEN_TOP);
   assign q_full   = (q_cnt == CW'(MAX_PKTS));
   assign q_empty  = (q_cnt == '0);

   // ---------------- receive side admission ----------------
   always_comb begin
      st_d        = st_q;
      take_byte   = 1'b0;
      refuse_slot = 1'b0;
      refuse_mem  = 1'b0;
      if (mac_valid) begin
         unique case (st_q)
            WR_IDLE: begin
               if (q_full)        refuse_slot = 1'b1;
               else if (mem_full) refuse_mem  = 1'b1;
               else               take_byte   = 1'b1;
            end
            WR_TAKE: begin
               if (mem_full || len_full) refuse_mem = 1'b1;
               else                      take_byte  = 1'b1;
            end
            default: ;
         endcase
         if (mac_eop)                         st_d = WR_IDLE;
         else if (take_byte)                  st_d = WR_TAKE;
         else if (refuse_slot || refuse_mem)  st_d = WR_SKIP;
      end
   end

   assign commit    = take_byte && mac_eop;
   assign push_desc = '{code: code_in, len: pkt_len + 1'b1};

   // ---------------- host side ----------------
   assign remain = q_head.len - rd_off;
   assign step   = (remain == LEN_W'(1)) ? LEN_W'(1) : LEN_W'(2);
   assign q_pop  = host_discard && !q_empty;
   assign rd_ok  = host_rd && !host_discard && !q_empty && (remain != '0);
   assign rd_bad = host_rd && !host_discard && (q_empty || (remain == '0));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= WR_IDLE;
         wptr_c     <= '0;
         wptr_t     <= '0;
         pkt_len    <= '0;
         rptr       <= '0;
         rd_off     <= '0;
         stat_ovr_q <= 1'b0;
         rx_ovr_q   <= 1'b0;
         rx_undr_q  <= 1'b0;
      end else if (rx_reset) begin
         st_q       <= WR_IDLE;
         wptr_c     <= '0;
         wptr_t     <= '0;
         pkt_len    <= '0;
         rptr       <= '0;
         rd_off     <= '0;
         stat_ovr_q <= 1'b0;
         rx_ovr_q   <= 1'b0;
         rx_undr_q  <= 1'b0;
      end else begin
         st_q <= st_d;
         if (take_byte) begin
            wptr_t  <= wptr_t + 1'b1;
            pkt_len <= pkt_len + 1'b1;
         end
         if (commit) begin
            wptr_c  <= wptr_t + 1'b1;
            pkt_len <= '0;
         end else if (refuse_mem && st_q == WR_TAKE) begin
            wptr_t  <= wptr_c;
            pkt_len <= '0;
         end

         if (q_pop) begin
            rptr   <= rptr + PW'(remain);
            rd_off <= '0;
         end else if (rd_ok) begin
            rptr   <= rptr + PW'(step);
            rd_off <= rd_off + step;
         end

         if (refuse_slot)                stat_ovr_q <= 1'b1;
         else if (q_pop)                 stat_ovr_q <= 1'b0;
         if (refuse_mem)                 rx_ovr_q   <= 1'b1;
         else if (q_pop || rd_ok)        rx_ovr_q   <= 1'b0;
         if (rd_bad)                     rx_undr_q  <= 1'b1;
      end
   end

   assign ra_hi = rptr[AW-1:0] + 1'b1;

   rxq_bytemem #(.DEPTH(DEPTH), .AW(AW)) u_mem (
      .clk      (clk),
      .we       (take_byte && !rx_reset),
      .waddr    (wptr_t[AW-1:0]),
      .wdata    (mac_byte),
      .raddr_lo (rptr[AW-1:0]),
      .raddr_hi (ra_hi),
      .rdata_lo (rd_lo),
      .rdata_hi (rd_hi)
   );

   rxq_statq #(.SLOTS(MAX_PKTS), .CW(CW)) u_statq (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (rx_reset),
      .push      (commit && !rx_reset),
      .push_desc (push_desc),
      .pop       (q_pop && !rx_reset),
      .head      (q_head),
      .count     (q_cnt)
   );

   assign head_status = q_empty ? {1'b1, 4'b0000, pkt_len}
                                : {1'b0, q_head.code, q_head.len};
   assign host_word   = (q_empty || remain == '0) ? 16'h0000
                      : {(remain == LEN_W'(1)) ? 8'h00 : rd_hi, rd_lo};

   assign flag_receiving = (st_q == WR_TAKE);
   assign flag_stat_ovr  = stat_ovr_q;
   assign flag_rx_ovr    = rx_ovr_q;
   assign flag_rx_undr   = rx_undr_q;
   assign adapter_fail   = rx_undr_q;

   // ---------------- assertions ----------------
   assert_undr_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n || rx_reset)
      flag_rx_undr |=> (flag_rx_undr && adapter_fail));

   assert_undr_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_rx_undr) |-> $past(host_rd));

   assert_statovr_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_stat_ovr) |-> ($past(host_discard) || $past(rx_reset)));

   assert_occupancy_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wptr_t - rptr) <= DEPTH_P);

   assert_reset_empties_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rx_reset |=> (head_status == 16'h8000 && !flag_receiving && !flag_stat_ovr
                    && !flag_rx_ovr && !flag_rx_undr));

endmodule

// File: tb/rxq_pktbuf_tb.sv
module rxq_pktbuf_tb;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        rx_reset;
   logic        mac_valid;
   logic [7:0]  mac_byte;
   logic        mac_eop;
   logic [3:0]  mac_code;
   logic        host_rd;
   logic        host_discard;
   logic [15:0] head_status;
   logic [15:0] host_word;
   logic        flag_receiving, flag_stat_ovr, flag_rx_ovr, flag_rx_undr, adapter_fail;

   int checks   = 0;
   int failures = 0;
   int cyc      = 0;
   bit done     = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   rxq_pktbuf u_dut (
      .clk            (clk),
      .rst_n          (rst_n),
      .rx_reset       (rx_reset),
      .mac_valid      (mac_valid),
      .mac_byte       (mac_byte),
      .mac_eop        (mac_eop),
      .mac_code       (mac_code),
      .host_rd        (host_rd),
      .host_discard   (host_discard),
      .head_status    (head_status),
      .host_word      (host_word),
      .flag_receiving (flag_receiving),
      .flag_stat_ovr  (flag_stat_ovr),
      .flag_rx_ovr    (flag_rx_ovr),
      .flag_rx_undr   (flag_rx_undr),
      .adapter_fail   (adapter_fail)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 150000 && !done) begin
         checks   = checks + 1;
         failures = failures + 1;
         $display("FAIL watchdog (all R) actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   function automatic logic [7:0] pb(input logic [7:0] seed, input int i);
      return seed + 8'(i * 7);
   endfunction

   function automatic logic [15:0] st_word(input logic [3:0] code, input int len);
      return {1'b0, code, 11'(len)};
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks = checks + 1;
      if (act !== exp) begin
         failures = failures + 1;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic send_pkt(input int len, input logic [3:0] code, input logic [7:0] seed);
      for (int i = 0; i < len; i++) begin
         mac_valid = 1'b1;
         mac_byte  = pb(seed, i);
         mac_eop   = (i == len - 1);
         mac_code  = code;
         @(negedge clk);
      end
      mac_valid = 1'b0;
      mac_eop   = 1'b0;
      mac_code  = 4'h0;
   endtask

   task automatic do_rd(output logic [15:0] w);
      w       = host_word;
      host_rd = 1'b1;
      @(negedge clk);
      host_rd = 1'b0;
   endtask

   task automatic do_discard();
      host_discard = 1'b1;
      @(negedge clk);
      host_discard = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1", "status", 32'(head_status), 32'h8000);
      chk("R1", "word", 32'(host_word), 32'h0);
      chk("R1", "flags", {27'd0, flag_receiving, flag_stat_ovr, flag_rx_ovr, flag_rx_undr, adapter_fail}, 32'h0);
   endtask

   task automatic t_encoding();
      logic [15:0] w;
      send_pkt(5, 4'b0000, 8'h10);
      chk("R2", "status len5", 32'(head_status), 32'(st_word(4'b0000, 5)));
      do_rd(w);
      chk("R4", "word0", 32'(w), {16'd0, pb(8'h10, 1), pb(8'h10, 0)});
      do_rd(w);
      chk("R4", "word1", 32'(w), {16'd0, pb(8'h10, 3), pb(8'h10, 2)});
      do_rd(w);
      chk("R4", "odd tail", 32'(w), {24'd0, pb(8'h10, 4)});
      chk("R4", "exhausted word", 32'(host_word), 32'h0);
      chk("R8", "no undr on exact read", 32'(flag_rx_undr), 32'h0);
      do_discard();
      chk("R9", "empty after discard", 32'(head_status), 32'h8000);
      send_pkt(60, 4'b1101, 8'h33);
      chk("R2", "crc status", 32'(head_status), 32'h683C);
      do_discard();
   endtask

   task automatic t_codes();
      logic [3:0] keep [6] = '{4'b1000, 4'b1011, 4'b1100, 4'b1101, 4'b1001, 4'b0010};
      logic [3:0] fold [5] = '{4'b0001, 4'b0011, 4'b0100, 4'b1111, 4'b0111};
      for (int k = 0; k < 6; k++) begin
         send_pkt(1, keep[k], 8'h50);
         chk("R3", "listed code kept", 32'(head_status), 32'(st_word(keep[k], 1)));
         do_discard();
      end
      for (int k = 0; k < 5; k++) begin
         send_pkt(1, fold[k], 8'h51);
         chk("R3", "other code folded", 32'(head_status), 32'(st_word(4'b0000, 1)));
         do_discard();
      end
   endtask

   task automatic t_order();
      logic [15:0] w;
      send_pkt(3, 4'b1000, 8'hA0);
      send_pkt(4, 4'b0000, 8'hB0);
      send_pkt(6, 4'b1100, 8'hC0);
      chk("R5", "first head", 32'(head_status), 32'(st_word(4'b1000, 3)));
      do_discard();
      chk("R5", "second head", 32'(head_status), 32'(st_word(4'b0000, 4)));
      do_rd(w);
      chk("R5", "second data", 32'(w), {16'd0, pb(8'hB0, 1), pb(8'hB0, 0)});
      do_discard();
      chk("R5", "third head", 32'(head_status), 32'(st_word(4'b1100, 6)));
      chk("R5", "third data", 32'(host_word), {16'd0, pb(8'hC0, 1), pb(8'hC0, 0)});
      do_discard();
   endtask

   task automatic t_discard();
      logic [15:0] w;
      send_pkt(7, 4'b0000, 8'h61);
      do_rd(w);
      do_discard();
      chk("R9", "partial discard empties", 32'(head_status), 32'h8000);
      do_discard();
      chk("R9", "empty discard no effect", 32'(head_status), 32'h8000);
      chk("R9", "empty discard flags", {29'd0, flag_stat_ovr, flag_rx_ovr, flag_rx_undr}, 32'h0);
      send_pkt(4, 4'b0000, 8'h71);
      chk("R9", "next packet aligned", 32'(host_word), {16'd0, pb(8'h71, 1), pb(8'h71, 0)});
      // discard and read together: discard wins, no underrun, no extra consumption
      host_rd = 1'b1;
      host_discard = 1'b1;
      @(negedge clk);
      host_rd = 1'b0;
      host_discard = 1'b0;
      chk("R9", "discard beats read", {15'd0, flag_rx_undr, head_status}, 32'h8000);
   endtask

   task automatic t_recv_flag();
      mac_valid = 1'b1; mac_byte = pb(8'h40, 0); mac_eop = 1'b0; mac_code = 4'h0;
      @(negedge clk);
      chk("R10", "receiving after byte0", 32'(flag_receiving), 32'h1);
      chk("R10", "live count 1", 32'(head_status), 32'h8001);
      mac_byte = pb(8'h40, 1);
      @(negedge clk);
      chk("R10", "live count 2", 32'(head_status), 32'h8002);
      mac_byte = pb(8'h40, 2); mac_eop = 1'b1; mac_code = 4'b1100;
      @(negedge clk);
      mac_valid = 1'b0; mac_eop = 1'b0; mac_code = 4'h0;
      chk("R10", "receiving low after eop", 32'(flag_receiving), 32'h0);
      chk("R10", "committed status", 32'(head_status), 32'(st_word(4'b1100, 3)));
      do_discard();
   endtask

   task automatic t_pkt_limit();
      for (int k = 0; k < 8; k++) send_pkt(2, 4'b0000, 8'(8'h20 + k));
      chk("R6", "no ovr at eight", 32'(flag_stat_ovr), 32'h0);
      send_pkt(2, 4'b0000, 8'h90);
      chk("R6", "ninth refused flag", 32'(flag_stat_ovr), 32'h1);
      chk("R6", "head unchanged", 32'(host_word), {16'd0, pb(8'h20, 1), pb(8'h20, 0)});
      do_discard();
      chk("R6", "flag clears on discard", 32'(flag_stat_ovr), 32'h0);
      for (int k = 1; k < 8; k++) begin
         chk("R6", "stored head data", 32'(host_word), {16'd0, pb(8'(8'h20 + k), 1), pb(8'(8'h20 + k), 0)});
         do_discard();
      end
      chk("R6", "ninth left nothing", 32'(head_status), 32'h8000);
   endtask

   task automatic t_overrun();
      logic [15:0] w;
      send_pkt(700, 4'b0000, 8'h01);
      send_pkt(700, 4'b0000, 8'h02);
      chk("R7", "no ovr while fits", 32'(flag_rx_ovr), 32'h0);
      send_pkt(700, 4'b0000, 8'h03);
      chk("R7", "overflow flag", 32'(flag_rx_ovr), 32'h1);
      send_pkt(10, 4'b0000, 8'hE0);
      chk("R7", "head still first", 32'(head_status), 32'(st_word(4'b0000, 700)));
      do_rd(w);
      chk("R7", "flag clears on read", 32'(flag_rx_ovr), 32'h0);
      do_discard();
      chk("R7", "second head", 32'(head_status), 32'(st_word(4'b0000, 700)));
      do_discard();
      chk("R7", "short packet after drop", 32'(head_status), 32'(st_word(4'b0000, 10)));
      chk("R7", "no partial bytes", 32'(host_word), {16'd0, pb(8'hE0, 1), pb(8'hE0, 0)});
      do_discard();
      chk("R7", "empty at end", 32'(head_status), 32'h8000);
   endtask

   task automatic t_underrun_reset();
      logic [15:0] w;
      do_rd(w);
      chk("R8", "read empty sets undr", {30'd0, flag_rx_undr, adapter_fail}, 32'h3);
      send_pkt(3, 4'b0000, 8'h5A);
      do_rd(w);
      do_rd(w);
      chk("R4", "one byte tail", 32'(w), {24'd0, pb(8'h5A, 2)});
      do_rd(w);
      do_discard();
      chk("R8", "sticky past discard", {30'd0, flag_rx_undr, adapter_fail}, 32'h3);
      send_pkt(2, 4'b0000, 8'h11);
      mac_valid = 1'b1; mac_byte = 8'hEE; mac_eop = 1'b0;
      @(negedge clk);
      mac_byte = 8'hEF;
      @(negedge clk);
      mac_valid = 1'b0;
      rx_reset = 1'b1;
      @(negedge clk);
      rx_reset = 1'b0;
      chk("R11", "status after rx_reset", 32'(head_status), 32'h8000);
      chk("R11", "flags after rx_reset",
          {27'd0, flag_receiving, flag_stat_ovr, flag_rx_ovr, flag_rx_undr, adapter_fail}, 32'h0);
      chk("R11", "word after rx_reset", 32'(host_word), 32'h0);
      send_pkt(3, 4'b1001, 8'h77);
      chk("R11", "fresh packet status", 32'(head_status), 32'(st_word(4'b1001, 3)));
      chk("R11", "fresh packet data", 32'(host_word), {16'd0, pb(8'h77, 1), pb(8'h77, 0)});
      do_discard();
   endtask

   initial begin
      rst_n = 1'b0; rx_reset = 1'b0;
      mac_valid = 1'b0; mac_byte = 8'h00; mac_eop = 1'b0; mac_code = 4'h0;
      host_rd = 1'b0; host_discard = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_encoding();
      t_codes();
      t_order();
      t_discard();
      t_recv_flag();
      t_pkt_limit();
      t_overrun();
      t_underrun_reset();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule